// File: doc/BRIEF.md
# Watermarked Sample FIFO Channel

This block is a single channel of a multi-channel audio transfer engine. It stores 32-bit sample words in a circular buffer of 512 entries, and the engine places one copy in each direction. For playback, the host or a DMA engine pushes words and the converter pops them. For capture, the converter pushes words and the host or DMA engine pops them. The storage, pointers and flags are the same in both directions.

Two thresholds come from one packed configuration word. The channel compares its occupancy against them every cycle and drives almost-full and almost-empty flags, as well as true full and true empty flags. A packed status word shows the raw read and write indices. Software uses these indices to work out free space or stored data. A push that finds the buffer full is dropped and raises a one-cycle overflow pulse. A synchronous clear input empties the channel in one cycle.

The bus decoder, the interrupt aggregation and the DMA request routing sit outside this block.

Top module: `sample_fifo_chan`

## Requirements
- R1: While `rstN` is low and after it is released, the channel is empty: `flagEmpty`=1, `flagFull`=0, `ptrStatus`=0, `overflowPulse`=0 and `popData`=0.
- R2: Words leave in the order they were accepted. When a pop is accepted at a clock edge, the oldest stored word appears on `popData` after that edge. `popData` then holds that word until the next accepted pop or reset.
- R3: A push while 512 words are stored, with no accepted pop in the same cycle, is dropped. The stored words and the write index do not change, and `overflowPulse` is high for exactly the one cycle after that edge.
- R4: A pop while the channel is empty is ignored. The read index does not change and `popData` keeps its previous value.
- R5: `ptrStatus` bits 25:16 carry the read index and bits 9:0 carry the write index. Each index counts 0 to 511 and wraps from 511 to 0, so bits 25, 9 and every other bit are 0. Except when full, the stored word count equals wr-rd when wr>=rd, and 512-rd+wr otherwise.
- R6: `flagFull` is 1 exactly when 512 words are stored, and `flagEmpty` is 1 exactly when none are stored.
- R7: `flagAlmostFull` is 1 exactly when the stored count is greater than or equal to the unsigned value of `wmCfg` bits 8:0.
- R8: `flagAlmostEmpty` is 1 exactly when the stored count is less than or equal to the unsigned value of `wmCfg` bits 24:16. The other bits of `wmCfg` have no effect.
- R9: When `clrReq` is high at an edge, both indices become 0 and the channel becomes empty after that edge. A push or pop in the same cycle is ignored, with no overflow pulse and no change to `popData`.
- R10: A push and a pop in the same cycle are both accepted when the channel is full, so the count stays 512 and there is no overflow. When the channel is empty, only the push is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clrReq | input | 1 | Synchronous clear of the channel |
| pushValid | input | 1 | Push request for pushData |
| pushData | input | 32 | Word to store |
| popReq | input | 1 | Pop request |
| popData | output | 32 | Last word popped |
| wmCfg | input | 32 | Bits 24:16 almost-empty threshold, bits 8:0 almost-full threshold |
| ptrStatus | output | 32 | Bits 25:16 read index, bits 9:0 write index |
| flagFull | output | 1 | 512 words stored |
| flagEmpty | output | 1 | No words stored |
| flagAlmostFull | output | 1 | Count at or above the almost-full threshold |
| flagAlmostEmpty | output | 1 | Count at or below the almost-empty threshold |
| overflowPulse | output | 1 | One-cycle pulse after a dropped push |

## Verification
A push, a pop and a clear can all arrive in the same cycle. The outcome depends on whether the channel is full, empty or in between at that moment. The bench drives push and pop together at exactly 512 words and at zero words, and asserts a clear at the same time as a push into a full channel. It also runs a long stretch of random coincident requests. A queue model in the bench judges every cycle, using the order pop first, then push, with clear overriding both.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Strobes from the control half to the storage half.
  typedef struct packed {
    logic wrEn;   // accepted push this cycle
    logic rdEn;   // accepted pop this cycle
    logic clr;    // synchronous clear this cycle
  } sfifoStrobe_t;

  // Field positions shared with the neighbouring register decoder.
  localparam int RD_FIELD_LSB = 16;
  localparam int WR_FIELD_LSB = 0;
  localparam int AE_FIELD_LSB = 16;
  localparam int AF_FIELD_LSB = 0;

endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CFG_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clrReq,
  input  logic                     pushValid,
  input  logic                     popReq,
  input  logic [CFG_W-1:0]         wmCfg,
  output sfifoStrobe_t             strobe,
  output logic [$clog2(DEPTH)-1:0] wrIdx,
  output logic [$clog2(DEPTH)-1:0] rdIdx,
  output logic [CFG_W-1:0]         ptrStatus,
  output logic                     flagFull,
  output logic                     flagEmpty,
  output logic                     flagAlmostFull,
  output logic                     flagAlmostEmpty,
  output logic                     overflowPulse
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int THR_W = IDX_W;
  localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] wrNext, rdNext;
  logic             rdOk, wrOk, ovfQ;
  logic [THR_W-1:0] afThr, aeThr;

  assign flagEmpty = (count == '0);
  assign flagFull  = (count == FULL_CNT);

  assign rdOk = popReq && !flagEmpty && !clrReq;
  assign wrOk = pushValid && !clrReq && (!flagFull || rdOk);

  assign strobe.wrEn = wrOk;
  assign strobe.rdEn = rdOk;
  assign strobe.clr  = clrReq;

  // Index advance: natural wrap for power-of-two depths, compare otherwise.
  generate
    if (POW2) begin : g_wrapPow2
      assign wrNext = wrIdx + 1'b1;
      assign rdNext = rdIdx + 1'b1;
    end else begin : g_wrapCmp
      assign wrNext = (wrIdx == LAST_IDX) ? '0 : wrIdx + 1'b1;
      assign rdNext = (rdIdx == LAST_IDX) ? '0 : rdIdx + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
      ovfQ  <= 1'b0;
    end else begin
      ovfQ <= pushValid && !clrReq && !wrOk;
      if (clrReq) begin
        wrIdx <= '0;
        rdIdx <= '0;
        count <= '0;
      end else begin
        if (wrOk) wrIdx <= wrNext;
        if (rdOk) rdIdx <= rdNext;
        if (wrOk && !rdOk)      count <= count + 1'b1;
        else if (rdOk && !wrOk) count <= count - 1'b1;
      end
    end
  end

  assign overflowPulse = ovfQ;

  // Watermark comparison against the packed threshold word.
  assign afThr = wmCfg[AF_FIELD_LSB +: THR_W];
  assign aeThr = wmCfg[AE_FIELD_LSB +: THR_W];
  assign flagAlmostFull  = (count >= CNT_W'(afThr));
  assign flagAlmostEmpty = (count <= CNT_W'(aeThr));

  always_comb begin
    ptrStatus = '0;
    ptrStatus[RD_FIELD_LSB +: IDX_W] = rdIdx;
    ptrStatus[WR_FIELD_LSB +: IDX_W] = wrIdx;
  end

  // R6: full and empty never together, count bounded by depth
  a_r6_full_excl_empty: assert property (@(posedge clk) disable iff (!rstN)
    !(flagFull && flagEmpty));
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R3: a push at full without a pop is dropped and pulses overflow
  a_r3_no_overflow_loss: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !clrReq && flagFull && !popReq) |=> (overflowPulse && $stable(wrIdx)));

  // R4: a pop at empty leaves the read index alone
  a_r4_empty_pop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && flagEmpty && !clrReq) |=> $stable(rdIdx));

  // R9: clear empties the channel on the next cycle with no overflow
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> (flagEmpty && wrIdx == '0 && rdIdx == '0 && !overflowPulse));

  // R10: push and pop together at full keep the channel full
  a_r10_full_swap: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && popReq && flagFull && !clrReq) |=> (flagFull && !overflowPulse));

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sfifoStrobe_t             strobe,
  input  logic [$clog2(DEPTH)-1:0] wrIdx,
  input  logic [$clog2(DEPTH)-1:0] rdIdx,
  input  logic [DATA_W-1:0]        pushData,
  output logic [DATA_W-1:0]        popData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrIdx] <= pushData;
  end

  // Read of the old word at rdIdx even when the same slot is rewritten.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            popData <= '0;
    else if (strobe.rdEn) popData <= mem[rdIdx];
  end

  // R4/R9: output holds whenever no pop is accepted
  a_r4_pop_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(popData));

  // R9: the control never accepts a transfer alongside a clear
  a_r9_clear_blocks: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |-> !(strobe.wrEn || strobe.rdEn));

endmodule

// File: rtl/sample_fifo_chan.sv
module sample_fifo_chan
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrReq,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  input  logic [CFG_W-1:0]  wmCfg,
  output logic [CFG_W-1:0]  ptrStatus,
  output logic              flagFull,
  output logic              flagEmpty,
  output logic              flagAlmostFull,
  output logic              flagAlmostEmpty,
  output logic              overflowPulse
);

  localparam int IDX_W = $clog2(DEPTH);

  sfifoStrobe_t     strobe;
  logic [IDX_W-1:0] wrIdx, rdIdx;

  sfifo_ctrl #(.DEPTH(DEPTH), .CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clrReq(clrReq), .pushValid(pushValid),
    .popReq(popReq), .wmCfg(wmCfg), .strobe(strobe), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .ptrStatus(ptrStatus), .flagFull(flagFull),
    .flagEmpty(flagEmpty), .flagAlmostFull(flagAlmostFull),
    .flagAlmostEmpty(flagAlmostEmpty), .overflowPulse(overflowPulse)
  );

  sfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .pushData(pushData), .popData(popData)
  );

endmodule

// File: tb/test_sample_fifo_chan.sv
`timescale 1ns/1ps
module test_sample_fifo_chan;

  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clrReq = 1'b0, pushValid = 1'b0, popReq = 1'b0;
  logic [31:0] pushData = '0, wmCfg = '0;
  logic [31:0] popData, ptrStatus;
  logic        flagFull, flagEmpty, flagAlmostFull, flagAlmostEmpty, overflowPulse;

  sample_fifo_chan i_sample_fifo_chan (
    .clk(clk), .rstN(rstN), .clrReq(clrReq), .pushValid(pushValid),
    .pushData(pushData), .popReq(popReq), .popData(popData), .wmCfg(wmCfg),
    .ptrStatus(ptrStatus), .flagFull(flagFull), .flagEmpty(flagEmpty),
    .flagAlmostFull(flagAlmostFull), .flagAlmostEmpty(flagAlmostEmpty),
    .overflowPulse(overflowPulse)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // Behavioural reference
  logic [31:0] q[$];
  logic [31:0] mPop = '0;
  logic        mOvf = 1'b0;
  int          mRd = 0, mWr = 0;
  logic [31:0] seq = 32'hA500_0000;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int n;
    n = q.size();
    chk("R2 popData", popData, mPop);
    chk("R5 ptrStatus", ptrStatus, (32'(mRd) << 16) | 32'(mWr));
    chk("R6 flagFull", 32'(flagFull), 32'(n == DEPTH));
    chk("R6 flagEmpty", 32'(flagEmpty), 32'(n == 0));
    chk("R7 flagAlmostFull", 32'(flagAlmostFull), 32'(n >= int'(wmCfg[8:0])));
    chk("R8 flagAlmostEmpty", 32'(flagAlmostEmpty), 32'(n <= int'(wmCfg[24:16])));
    chk("R3 overflowPulse", 32'(overflowPulse), 32'(mOvf));
  endtask

  // One clock: inputs set away from the edge, model stepped, outputs compared.
  task automatic cyc(bit pu, bit po, bit cl);
    bit canPop, canPush;
    pushValid = pu; popReq = po; clrReq = cl;
    pushData = seq;
    @(posedge clk);
    if (cl) begin
      q.delete(); mRd = 0; mWr = 0; mOvf = 1'b0;
    end else begin
      canPop  = po && (q.size() > 0);
      canPush = pu && (q.size() < DEPTH || canPop);
      if (canPop) begin
        mPop = q.pop_front();
        mRd = (mRd + 1) % DEPTH;
      end
      if (canPush) begin
        q.push_back(seq);
        mWr = (mWr + 1) % DEPTH;
      end
      mOvf = pu && !canPush;
    end
    if (pu) seq = seq + 32'h0001_0003;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R8: junk outside the threshold fields must not matter; ae=3, af=5
    wmCfg = 32'hFE03_FE05;
    repeat (3) @(negedge clk);
    chk("R1 flagEmpty in reset", 32'(flagEmpty), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ptrStatus", ptrStatus, 32'd0);
    chk("R1 popData", popData, 32'd0);
    chk("R1 flagFull", 32'(flagFull), 32'd0);
    chk("R1 overflowPulse", 32'(overflowPulse), 32'd0);
    compareAll();

    // R2/R7/R8: fill past the thresholds, then drain with overlap
    for (int i = 0; i < 8; i++) cyc(1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(1, 1, 0);
    for (int i = 0; i < 8; i++) cyc(0, 1, 0);
    // R4: pops from empty keep the last word
    begin
      logic [31:0] lastWord;
      lastWord = popData;
      cyc(0, 1, 0);
      cyc(0, 1, 0);
      chk("R4 empty pop holds data", popData, lastWord);
      chk("R4 empty pop holds read index", ptrStatus[25:16], 32'(mRd));
    end
    // R10: push+pop while empty accepts only the push
    cyc(1, 1, 0);
    chk("R10 empty swap count one", 32'(flagEmpty), 32'd0);
    cyc(0, 1, 0);

    // R3/R5/R6: fill to 512 (wraps write index), overrun twice
    wmCfg = 32'h000A_01F4;
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0);
    chk("R6 full after 512", 32'(flagFull), 32'd1);
    cyc(1, 0, 0);
    chk("R3 overflow pulse", 32'(overflowPulse), 32'd1);
    cyc(0, 0, 0);
    chk("R3 pulse lasts one cycle", 32'(overflowPulse), 32'd0);
    cyc(1, 0, 0);
    // R10: push and pop together at full
    cyc(1, 1, 0);
    chk("R10 full swap stays full", 32'(flagFull), 32'd1);
    chk("R10 full swap no overflow", 32'(overflowPulse), 32'd0);
    for (int i = 0; i < 300; i++) cyc(i % 3 == 0, 1, 0);

    // R9: clear with a push into a full channel, and with a pop
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0);
    begin
      logic [31:0] held;
      held = popData;
      cyc(1, 1, 1);
      chk("R9 clear empties", 32'(flagEmpty), 32'd1);
      chk("R9 clear zeroes indices", ptrStatus, 32'd0);
      chk("R9 clear suppresses overflow", 32'(overflowPulse), 32'd0);
      chk("R9 clear keeps popData", popData, held);
    end

    // Random coincidences, mid-range thresholds
    wmCfg = 32'h5A40_A5C0;
    for (int i = 0; i < 6000; i++) begin
      bit pu, po, cl;
      pu = ($urandom % 100) < 55;
      po = ($urandom % 100) < 45;
      cl = ($urandom % 400) == 0;
      cyc(pu, po, cl);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule